// File: doc/BRIEF.md
# Rounding Lane-Wise Logical Right Shift Unit

This block is a single-operation SIMD execution slice. Each cycle it may accept one 32-bit instruction word together with a 128-bit source vector. It checks that the word encodes a rounded logical right shift by an immediate. It then cuts the vector into equal lanes of 8, 16, 32 or 64 bits and shifts every lane right, filling with zeros, by the same count taken from the instruction. A lane shifted by a nonzero count gets back its most significant discarded bit as a rounding increment. A count of zero returns the lane untouched.

The element size and the count share one packed 7-bit field. A prefix code in that field chooses the lane width, and the remaining bits hold the count. The result, the destination register number and a flag for unrecognised encodings are registered, and they appear one cycle after the request. The register file, the exception logic and hazard handling sit outside this slice.

Top module: `vec_rshr_unit`

## Requirements
- R1: An accepted word is legal only if bits [31:26]=011110, bits [25:23]=011, bits [5:0]=001010 and the field in bits [22:16] is not of the form 1111xxx. Any other word raises reserved_instr together with out_valid in the cycle that follows.
- R2: The field in bits [22:16] selects the lane width and the count m. 0mmmmmm gives 64-bit lanes with a 6-bit m, 10mmmmm gives 32-bit lanes with a 5-bit m, 110mmmm gives 16-bit lanes with a 4-bit m, and 1110mmm gives 8-bit lanes with a 3-bit m.
- R3: Lane i occupies result bits [w*i+w-1 : w*i], with lane 0 in the least significant bits. Lanes are computed independently, and a rounding carry never crosses a lane boundary.
- R4: When m is 0, every lane of result equals the matching lane of src.
- R5: When m is nonzero, each lane equals (lane >> m) + bit m-1 of the original lane, with zeros shifted in at the top.
- R6: out_valid is high exactly in the cycle after in_valid was high. dst_idx then equals bits [10:6] of the accepted word.
- R7: For a reserved word, result reads zero.
- R8: While reset is active, and after reset until the first request, out_valid, reserved_instr and result are all zero.
- R9: In a cycle without in_valid, result and dst_idx keep their previous values, and out_valid and reserved_instr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe for instr and src |
| instr | input | 32 | Instruction word |
| src | input | 128 | Source vector |
| out_valid | output | 1 | Registered result strobe |
| dst_idx | output | 5 | Destination register number from the word |
| result | output | 128 | Shifted and rounded vector |
| reserved_instr | output | 1 | Word not recognised |

## Verification
The assertions check on every cycle the timing relations at the ports: the one-cycle strobe latency, dst_idx taken from the word, the reserved flag paired with out_valid and a zero result, holding when idle, rejection of a wrong major opcode, and pass-through for a 64-bit zero count. The arithmetic inside each lane can only be shown by the bench's scenarios. These include rounding at the largest count for every width, all-ones lanes whose increment could carry into a neighbour, alternating and random data, and each reserved field pattern, all compared against an independent per-lane model.

// File: rtl/vec_rshr_pkg.sv
package vec_rshr_pkg;

  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int AMT_W     = 6;
  localparam int N_FMT     = 4;

  localparam logic [5:0] MAJOR_OPC = 6'b011110;
  localparam logic [2:0] SUB_OPC   = 3'b011;
  localparam logic [5:0] MINOR_OPC = 6'b001010;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  typedef struct packed {
    logic                 legal;
    esize_e               esz;
    logic [AMT_W-1:0]     amt;
    logic [REG_IDX_W-1:0] dst_reg;
  } op_dec_t;

endpackage

// File: rtl/vec_rshr_rst_sync.sv
module vec_rshr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vec_rshr_decode.sv
module vec_rshr_decode
  import vec_rshr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output op_dec_t            dec
);
  logic [6:0] fld;
  logic       opc_ok;
  logic       fmt_ok;
  esize_e     esz;
  logic [AMT_W-1:0] amt;
  logic       unused_src_reg;

  assign fld            = instr[22:16];
  assign unused_src_reg = ^instr[15:11];
  assign opc_ok = (instr[31:26] == MAJOR_OPC) && (instr[25:23] == SUB_OPC) &&
                  (instr[5:0] == MINOR_OPC);

  // prefix code: leading ones count picks the lane size
  always_comb begin
    fmt_ok = 1'b1;
    esz    = ESZ_8;
    amt    = '0;
    casez (fld)
      7'b0??????: begin esz = ESZ_64; amt = fld[5:0];          end
      7'b10?????: begin esz = ESZ_32; amt = {1'b0, fld[4:0]};  end
      7'b110????: begin esz = ESZ_16; amt = {2'b0, fld[3:0]};  end
      7'b1110???: begin esz = ESZ_8;  amt = {3'b0, fld[2:0]};  end
      default:    fmt_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec.legal   = opc_ok & fmt_ok;
    dec.esz     = esz;
    dec.amt     = amt;
    dec.dst_reg = instr[10:6];
  end
endmodule

// File: rtl/vec_rshr_lane.sv
module vec_rshr_lane #(
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] din,
  input  logic [AW-1:0]     amt,
  output logic [LANE_W-1:0] dout
);
  logic [LANE_W-1:0] shifted;
  logic              round_bit;

  always_comb begin
    shifted   = din >> amt;
    round_bit = (|amt) & din[amt - 1'b1];
    dout      = shifted + {{(LANE_W-1){1'b0}}, round_bit};
  end
endmodule

// File: rtl/vec_rshr_array.sv
module vec_rshr_array #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8,
  localparam int NLANE = VEC_W / LANE_W,
  localparam int AW    = $clog2(LANE_W)
) (
  input  logic [VEC_W-1:0] src,
  input  logic [AW-1:0]    amt,
  output logic [VEC_W-1:0] dout
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    vec_rshr_lane #(.LANE_W(LANE_W)) lane_i (
      .din  (src [i*LANE_W +: LANE_W]),
      .amt  (amt),
      .dout (dout[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vec_rshr_datapath.sv
module vec_rshr_datapath
  import vec_rshr_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8
) (
  input  logic [VEC_W-1:0] src,
  input  esize_e           esz,
  input  logic [AMT_W-1:0] amt,
  output logic [VEC_W-1:0] dout
);
  logic [VEC_W-1:0] res_fmt [N_FMT];

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int LW = MIN_LANE_W << g;
    localparam int AW = $clog2(LW);
    vec_rshr_array #(.VEC_W(VEC_W), .LANE_W(LW)) arr_i (
      .src  (src),
      .amt  (amt[AW-1:0]),
      .dout (res_fmt[g])
    );
  end

  always_comb dout = res_fmt[esz];
endmodule

// File: rtl/vec_rshr_unit.sv
module vec_rshr_unit
  import vec_rshr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [VEC_W-1:0]     src,
  output logic                 out_valid,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [VEC_W-1:0]     result,
  output logic                 reserved_instr
);
  logic             arst_sync_n;
  op_dec_t          dec;
  logic [VEC_W-1:0] dp_res;

  logic                 vld_d, vld_q;
  logic                 rsv_d, rsv_q;
  logic                 load_en;
  logic [VEC_W-1:0]     res_d, res_q;
  logic [REG_IDX_W-1:0] dst_d, dst_q;

  vec_rshr_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(arst_sync_n)
  );

  vec_rshr_decode dec_i (.instr(instr), .dec(dec));

  vec_rshr_datapath #(.VEC_W(VEC_W), .MIN_LANE_W(8)) dp_i (
    .src(src), .esz(dec.esz), .amt(dec.amt), .dout(dp_res)
  );

  // next state
  always_comb begin
    load_en = in_valid;
    vld_d   = in_valid;
    rsv_d   = in_valid & ~dec.legal;
    res_d   = dec.legal ? dp_res : '0;
    dst_d   = dec.dst_reg;
  end

  // registers
  always_ff @(posedge clk or negedge arst_sync_n) begin
    if (!arst_sync_n) begin
      vld_q <= 1'b0;
      rsv_q <= 1'b0;
      res_q <= '0;
      dst_q <= '0;
    end else begin
      vld_q <= vld_d;
      rsv_q <= rsv_d;
      if (load_en) begin
        res_q <= res_d;
        dst_q <= dst_d;
      end
    end
  end

  assign out_valid      = vld_q;
  assign reserved_instr = rsv_q;
  assign result         = res_q;
  assign dst_idx        = dst_q;
endmodule

// File: rtl/vec_rshr_unit_chk.sv
module vec_rshr_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic [VEC_W-1:0] src,
  input logic             out_valid,
  input logic [4:0]       dst_idx,
  input logic [VEC_W-1:0] result,
  input logic             reserved_instr
);
  logic opc_match;
  assign opc_match = (instr[31:26] == 6'b011110) && (instr[25:23] == 3'b011) &&
                     (instr[5:0] == 6'b001010);

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !reserved_instr));
  a_r6_dst_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dst_idx == $past(instr[10:6])));
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_instr |-> (out_valid && result == '0));
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(dst_idx)));
  a_r1_bad_major: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] != 6'b011110) |=> reserved_instr);
  a_r4_zero_shift_d: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc_match && instr[22:16] == 7'b0) |=> (result == $past(src)));
endmodule

bind vec_rshr_unit vec_rshr_unit_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(arst_sync_n), .in_valid(in_valid), .instr(instr), .src(src),
  .out_valid(out_valid), .dst_idx(dst_idx), .result(result),
  .reserved_instr(reserved_instr)
);

// File: tb/vec_rshr_unit_tb.sv
`timescale 1ns/1ps
module vec_rshr_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src;
  logic         out_valid;
  logic [4:0]   dst_idx;
  logic [127:0] result;
  logic         reserved_instr;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic [4:0]   dst;
    logic         rsv;
  } exp_t;
  exp_t exp_q[$];
  logic [127:0] last_res;
  logic [4:0]   last_dst;

  always #2 clk = ~clk;

  vec_rshr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(out_valid), .dst_idx(dst_idx), .result(result),
    .reserved_instr(reserved_instr)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] fld, input logic [4:0] ws,
                                     input logic [4:0] wd);
    return {6'b011110, 3'b011, fld, ws, wd, 6'b001010};
  endfunction

  function automatic logic [6:0] fmt(input int w, input int m);
    case (w)
      64:      return {1'b0, 6'(m)};
      32:      return {2'b10, 5'(m)};
      16:      return {3'b110, 4'(m)};
      default: return {4'b1110, 3'(m)};
    endcase
  endfunction

  // independent reference: decode, then per-lane shift with rounding
  function automatic exp_t model(input logic [31:0] iw, input logic [127:0] v);
    exp_t e;
    int w, m;
    bit ok;
    logic [127:0] mask, x, r;
    ok = (iw[31:26] == 6'b011110) && (iw[25:23] == 3'b011) && (iw[5:0] == 6'b001010);
    w = 0; m = 0;
    if (!iw[22])      begin w = 64; m = int'(iw[21:16]); end
    else if (!iw[21]) begin w = 32; m = int'(iw[20:16]); end
    else if (!iw[20]) begin w = 16; m = int'(iw[19:16]); end
    else if (!iw[19]) begin w = 8;  m = int'(iw[18:16]); end
    else ok = 1'b0;
    e.dst = iw[10:6];
    e.rsv = !ok;
    e.res = '0;
    if (ok) begin
      mask = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 128'd1);
      for (int i = 0; i < 128 / w; i++) begin
        x = (v >> (w * i)) & mask;
        if (m == 0) r = x;
        else        r = (x >> m) + ((x >> (m - 1)) & 128'd1);
        e.res = e.res | ((r & mask) << (w * i));
      end
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] iw, input logic [127:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = iw;
    src      = v;
    exp_q.push_back(model(iw, v));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr    = $urandom;
      src      = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected out_valid", 128'(out_valid), 128'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(result == e.res, e.rsv ? "R7 reserved result" : "R3 R4 R5 lane result",
              result, e.res);
          chk(dst_idx == e.dst, "R6 dst_idx", 128'(dst_idx), 128'(e.dst));
          chk(reserved_instr == e.rsv, "R1 R2 reserved_instr",
              128'(reserved_instr), 128'(e.rsv));
          last_res = e.res;
          last_dst = e.dst;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wl[4] = '{8, 16, 32, 64};
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", 128'(out_valid), 128'd0);
    chk(reserved_instr == 1'b0, "R8 reserved in reset", 128'(reserved_instr), 128'd0);
    chk(result == '0, "R8 result in reset", result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", 128'(out_valid), 128'd0);
    chk(result == '0, "R8 result after reset", result, 128'd0);

    // R4 zero count and R5 boundaries per width, R3 all-ones carry containment
    foreach (wl[j]) begin
      send(mk(fmt(wl[j], 0), 5'd1, 5'd3), 128'hF00D_CAFE_1234_5678_9ABC_DEF0_0F1E_2D3C);
      send(mk(fmt(wl[j], 1), 5'd2, 5'd4), {128{1'b1}});
      send(mk(fmt(wl[j], wl[j] - 1), 5'd3, 5'd31), {128{1'b1}});
      send(mk(fmt(wl[j], wl[j] - 1), 5'd4, 5'd0), {16{8'h80}});
      send(mk(fmt(wl[j], wl[j] / 2), 5'd5, 5'd17), {32{4'hA}});
      send(mk(fmt(wl[j], 2), 5'd6, 5'd9), {32{4'h5}});
    end
    idle(3);
    // R9 hold after idle
    chk(result == last_res, "R9 result held when idle", result, last_res);
    chk(dst_idx == last_dst, "R9 dst held when idle", 128'(dst_idx), 128'(last_dst));
    chk(out_valid == 1'b0, "R9 out_valid low when idle", 128'(out_valid), 128'd0);

    // R1 reserved encodings (R7 result zero)
    send({6'b011111, 3'b011, 7'd5, 5'd1, 5'd7, 6'b001010}, {128{1'b1}});
    send({6'b011110, 3'b010, 7'd5, 5'd1, 5'd8, 6'b001010}, {128{1'b1}});
    send({6'b011110, 3'b011, 7'd5, 5'd1, 5'd9, 6'b001011}, {128{1'b1}});
    send(mk(7'b1111000, 5'd1, 5'd10), {128{1'b1}});
    send(mk(7'b1111111, 5'd1, 5'd11), {128{1'b1}});
    send(mk(fmt(16, 3), 5'd1, 5'd12), {8{16'h0018}});
    idle(2);

    // random mix, back to back with gaps
    for (int n = 0; n < 60; n++) begin
      int w;
      w = wl[$urandom_range(3, 0)];
      send(mk(fmt(w, int'($urandom_range(w - 1, 0))), 5'($urandom), 5'($urandom)),
           {$urandom, $urandom, $urandom, $urandom});
      if ((n % 7) == 6) idle(1);
    end
    idle(3);
    chk(exp_q.size() == 0, "R6 all results delivered", 128'(exp_q.size()), 128'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule